// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind an I2C bus engine that has already turned the serial line into whole bytes and START/STOP events. After each START it inspects the address byte or bytes and decides whether the local device is the target. It handles plain 7-bit addresses and two-byte 10-bit addresses, and it recognises the general-call address. For each address byte it tells the bus engine whether to acknowledge.

The programmed own address and the addressing mode come in as static configuration. The bus engine gives a byte strobe with the byte value and marks it as the first or second byte after a START. The results are these flags: device selected, address zero received, transfer direction, general call seen in this transaction, and acknowledge request. A one-cycle interrupt pulse is raised whenever the device is selected or a general call arrives. Every output is registered and changes on the clock edge that samples the causing strobe.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, slv_sel, zero_addr, dir_rd, ack_req, gc_seen and addr_irq are all 0.
- R2: In 7-bit mode (cfg_ten_bit=0), a first byte whose bits 7..1 equal cfg_own_addr[6:0] sets slv_sel=1 and ack_req=1 on the next cycle.
- R3: On a 7-bit match, dir_rd takes bit 0 of that first byte (1 means read).
- R4: With GC_EN=1, a first byte of 0x00 in either mode sets zero_addr=1, gc_seen=1 and ack_req=1, clears slv_sel and dir_rd, and pulses addr_irq.
- R5: In 10-bit mode, a first byte of 11110, cfg_own_addr[9:8] and write bit 0 gives ack_req=1 with slv_sel still 0. A following second byte equal to cfg_own_addr[7:0] then sets slv_sel=1, ack_req=1 and pulses addr_irq. A mismatch in either byte gives ack_req=0 and slv_sel=0.
- R6: STOP clears slv_sel, zero_addr, dir_rd, ack_req and gc_seen. A first byte that matches nothing clears slv_sel, zero_addr and ack_req, but gc_seen and dir_rd keep their values.
- R7: In 10-bit mode, after a full two-byte match and with no STOP since, a first byte of 11110, cfg_own_addr[9:8], 1 sets slv_sel=1, dir_rd=1, ack_req=1 and pulses addr_irq. Without that earlier match the same byte is not acknowledged.
- R8: Only the compare of the selected mode applies. A 7-bit own-address byte does not match in 10-bit mode, and a 10-bit header byte does not match in 7-bit mode.
- R9: STOP takes priority over START, and START over a byte strobe in the same cycle. START clears ack_req and any half-done 10-bit match, and leaves slv_sel, zero_addr and dir_rd as they were.
- R10: addr_irq lasts exactly one cycle. ack_req holds until the next byte, START or STOP. A byte that is not an address byte drives ack_req to 0 and leaves slv_sel unchanged.
- R11: With GC_EN=0, a first byte of 0x00 is compared like any other address, so it selects the device when the own 7-bit address is 0 and never sets gc_seen or zero_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| cfg_own_addr | input | 10 | Own address; bits 6..0 are used in 7-bit mode |
| rx_valid | input | 1 | Received byte strobe |
| rx_first | input | 1 | Strobed byte is the first after START |
| rx_second | input | 1 | Strobed byte is the second after START |
| rx_byte | input | 8 | Received byte value |
| bus_start | input | 1 | START or repeated START seen |
| bus_stop | input | 1 | STOP seen |
| slv_sel | output | 1 | Device is addressed as slave |
| zero_addr | output | 1 | Address zero received |
| dir_rd | output | 1 | Transfer direction, 1 = read |
| ack_req | output | 1 | Acknowledge request for the last byte |
| gc_seen | output | 1 | General call seen since the last STOP |
| addr_irq | output | 1 | One-cycle pulse on selection or general call |

## Verification
The main instance uses GC_EN=1 with own address 0x2A5. This puts the 7-bit address 0x25 and the 10-bit header bits 10 within reach, so the bench can exercise both modes, repeated-START reads and header mismatches in one run. A second instance uses GC_EN=0 with own address 0. On that instance a 0x00 byte is compared as an ordinary address, which brings the disabled general-call path within reach.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
    localparam int BYTE_W = 8;
    localparam int A7_W   = 7;
    localparam int A10_W  = 10;
    localparam int HI_W   = A10_W - BYTE_W;
    localparam int PFX_W  = BYTE_W - HI_W - 1;
    localparam logic [PFX_W-1:0] TEN_PFX = 5'b11110;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_GCALL,
        CLS_OWN7,
        CLS_TEN_HI,
        CLS_TEN_RD
    } first_cls_e;

    typedef struct packed {
        logic sel;
        logic zero;
        logic dir;
        logic ack;
        logic gc;
        logic irq;
        logic hi_ok;
        logic ten_done;
    } am_state_s;
endpackage

// File: rtl/i2c_am_first_dec.sv
module i2c_am_first_dec
    import i2c_am_pkg::*;
#(
    parameter bit GC_EN = 1'b1
) (
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              ten_mode,
    input  logic [A7_W-1:0]   own7,
    input  logic [HI_W-1:0]   own_hi,
    input  logic              ten_done,
    output first_cls_e        cls
);
    logic gc_hit;
    logic own7_hit;
    logic hdr_hit;

    generate
        if (GC_EN) begin : g_gc
            assign gc_hit = (rx_byte == '0);
        end else begin : g_nogc
            assign gc_hit = 1'b0;
        end
    endgenerate

    assign own7_hit = (rx_byte[BYTE_W-1:1] == own7);
    assign hdr_hit  = (rx_byte[BYTE_W-1 -: PFX_W] == TEN_PFX) &&
                      (rx_byte[HI_W:1] == own_hi);

    always_comb begin
        cls = CLS_NONE;
        if (gc_hit) begin
            cls = CLS_GCALL;
        end else if (!ten_mode) begin
            if (own7_hit) cls = CLS_OWN7;
        end else if (hdr_hit) begin
            if (!rx_byte[0])   cls = CLS_TEN_HI;
            else if (ten_done) cls = CLS_TEN_RD;
        end
    end
endmodule

// File: rtl/i2c_am_lo_cmp.sv
module i2c_am_lo_cmp
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] own_lo,
    output logic              lo_hit
);
    assign lo_hit = (rx_byte == own_lo);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter bit GC_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ten_bit,
    input  logic [A10_W-1:0]  cfg_own_addr,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic              rx_second,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              bus_start,
    input  logic              bus_stop,
    output logic              slv_sel,
    output logic              zero_addr,
    output logic              dir_rd,
    output logic              ack_req,
    output logic              gc_seen,
    output logic              addr_irq
);
    am_state_s  s_d, s_q;
    first_cls_e cls;
    logic       lo_hit;

    i2c_am_first_dec #(.GC_EN(GC_EN)) u_first (
        .rx_byte  (rx_byte),
        .ten_mode (cfg_ten_bit),
        .own7     (cfg_own_addr[A7_W-1:0]),
        .own_hi   (cfg_own_addr[A10_W-1 -: HI_W]),
        .ten_done (s_q.ten_done),
        .cls      (cls)
    );

    i2c_am_lo_cmp u_lo (
        .rx_byte (rx_byte),
        .own_lo  (cfg_own_addr[BYTE_W-1:0]),
        .lo_hit  (lo_hit)
    );

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (bus_stop) begin
            s_d.sel      = 1'b0;
            s_d.zero     = 1'b0;
            s_d.dir      = 1'b0;
            s_d.ack      = 1'b0;
            s_d.gc       = 1'b0;
            s_d.hi_ok    = 1'b0;
            s_d.ten_done = 1'b0;
        end else if (bus_start) begin
            s_d.ack   = 1'b0;
            s_d.hi_ok = 1'b0;
        end else if (rx_valid && rx_first) begin
            s_d.hi_ok = 1'b0;
            s_d.zero  = 1'b0;
            s_d.ack   = 1'b1;
            unique case (cls)
                CLS_GCALL: begin
                    s_d.zero     = 1'b1;
                    s_d.gc       = 1'b1;
                    s_d.sel      = 1'b0;
                    s_d.dir      = 1'b0;
                    s_d.irq      = 1'b1;
                    s_d.ten_done = 1'b0;
                end
                CLS_OWN7: begin
                    s_d.sel = 1'b1;
                    s_d.dir = rx_byte[0];
                    s_d.irq = 1'b1;
                end
                CLS_TEN_HI: begin
                    s_d.sel      = 1'b0;
                    s_d.dir      = 1'b0;
                    s_d.hi_ok    = 1'b1;
                    s_d.ten_done = 1'b0;
                end
                CLS_TEN_RD: begin
                    s_d.sel = 1'b1;
                    s_d.dir = 1'b1;
                    s_d.irq = 1'b1;
                end
                default: begin
                    s_d.sel      = 1'b0;
                    s_d.ack      = 1'b0;
                    s_d.ten_done = 1'b0;
                end
            endcase
        end else if (rx_valid) begin
            s_d.ack   = 1'b0;
            s_d.hi_ok = 1'b0;
            if (s_q.hi_ok && rx_second && lo_hit) begin
                s_d.sel      = 1'b1;
                s_d.dir      = 1'b0;
                s_d.ack      = 1'b1;
                s_d.irq      = 1'b1;
                s_d.ten_done = 1'b1;
            end else if (s_q.hi_ok && rx_second) begin
                s_d.sel = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign slv_sel   = s_q.sel;
    assign zero_addr = s_q.zero;
    assign dir_rd    = s_q.dir;
    assign ack_req   = s_q.ack;
    assign gc_seen   = s_q.gc;
    assign addr_irq  = s_q.irq;
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk
    import i2c_am_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_ten_bit,
    input logic [A10_W-1:0]  cfg_own_addr,
    input logic              rx_valid,
    input logic              rx_first,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              bus_start,
    input logic              bus_stop,
    input logic              slv_sel,
    input logic              zero_addr,
    input logic              dir_rd,
    input logic              ack_req,
    input logic              gc_seen,
    input logic              addr_irq
);
    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_irq |=> !addr_irq);

    // R6
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (!slv_sel && !zero_addr && !ack_req && !gc_seen && !dir_rd));

    // R3
    dir_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_first && !bus_stop && !bus_start && !cfg_ten_bit &&
         rx_byte != '0 && rx_byte[BYTE_W-1:1] == cfg_own_addr[A7_W-1:0])
        |=> (slv_sel && dir_rd == $past(rx_byte[0])));

    // R9
    start_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !bus_stop) |=> (!ack_req && slv_sel == $past(slv_sel)));

    // R4
    zero_gc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_addr |-> gc_seen);

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_irq |-> (slv_sel || zero_addr));
endmodule

bind i2c_addr_match i2c_am_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_ten_bit  (cfg_ten_bit),
    .cfg_own_addr (cfg_own_addr),
    .rx_valid     (rx_valid),
    .rx_first     (rx_first),
    .rx_byte      (rx_byte),
    .bus_start    (bus_start),
    .bus_stop     (bus_stop),
    .slv_sel      (slv_sel),
    .zero_addr    (zero_addr),
    .dir_rd       (dir_rd),
    .ack_req      (ack_req),
    .gc_seen      (gc_seen),
    .addr_irq     (addr_irq)
);

// File: tb/i2c_addr_match_tb_top.sv
`timescale 1ns/1ps
module i2c_addr_match_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_ten_bit = 1'b0;
    logic [9:0] cfg_own_addr = 10'h2A5;
    logic       rx_valid = 1'b0, rx_first = 1'b0, rx_second = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       bus_start = 1'b0, bus_stop = 1'b0;
    logic       slv_sel, zero_addr, dir_rd, ack_req, gc_seen, addr_irq;
    logic       n_sel, n_zero, n_dir, n_ack, n_gc, n_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] exp;
        bit         chk2;
        logic [5:0] exp2;
        string      tag;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    i2c_addr_match #(.GC_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ten_bit(cfg_ten_bit), .cfg_own_addr(cfg_own_addr),
        .rx_valid(rx_valid), .rx_first(rx_first), .rx_second(rx_second), .rx_byte(rx_byte),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .slv_sel(slv_sel), .zero_addr(zero_addr), .dir_rd(dir_rd), .ack_req(ack_req),
        .gc_seen(gc_seen), .addr_irq(addr_irq)
    );

    i2c_addr_match #(.GC_EN(1'b0)) dut_nogc_i (
        .clk(clk), .rst_n(rst_n), .cfg_ten_bit(cfg_ten_bit), .cfg_own_addr(10'h000),
        .rx_valid(rx_valid), .rx_first(rx_first), .rx_second(rx_second), .rx_byte(rx_byte),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .slv_sel(n_sel), .zero_addr(n_zero), .dir_rd(n_dir), .ack_req(n_ack),
        .gc_seen(n_gc), .addr_irq(n_irq)
    );

    // expected vector order: {sel, zero, dir, ack, gc, irq}
    task automatic ev(input bit st, input bit sp, input bit v, input bit f, input bit s,
                      input logic [7:0] b, input logic [5:0] e, input string tag,
                      input bit c2 = 1'b0, input logic [5:0] e2 = 6'b0);
        item_t it;
        @(negedge clk);
        bus_start = st; bus_stop = sp; rx_valid = v; rx_first = f; rx_second = s; rx_byte = b;
        it.exp = e; it.chk2 = c2; it.exp2 = e2; it.tag = tag;
        exp_q.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                item_t it;
                logic [5:0] act;
                it = exp_q.pop_front();
                act = {slv_sel, zero_addr, dir_rd, ack_req, gc_seen, addr_irq};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
                end
                if (it.chk2) begin
                    act = {n_sel, n_zero, n_dir, n_ack, n_gc, n_irq};
                    checks++;
                    if (act !== it.exp2) begin
                        errors++;
                        $display("FAIL %s (no general call): actual %b expected %b", it.tag, act, it.exp2);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        checks++;
        if ({slv_sel, zero_addr, dir_rd, ack_req, gc_seen, addr_irq} !== 6'b0) begin
            errors++;
            $display("FAIL R1: actual %b expected 000000",
                     {slv_sel, zero_addr, dir_rd, ack_req, gc_seen, addr_irq});
        end
        rst_n = 1'b1;
        // 7-bit mode, own 7-bit address 0x25
        ev(1,0,0,0,0,8'h00, 6'b000000, "R9 start idle");
        ev(0,0,1,1,0,8'h4A, 6'b100101, "R2 write match");
        ev(0,0,0,0,0,8'h00, 6'b100100, "R10 ack held, irq gone");
        ev(0,0,1,0,0,8'h33, 6'b100000, "R10 data byte");
        ev(0,1,0,0,0,8'h00, 6'b000000, "R6 stop clears");
        ev(1,0,0,0,0,8'h00, 6'b000000, "R9 start");
        ev(0,0,1,1,0,8'h4B, 6'b101101, "R3 read match");
        ev(1,0,0,0,0,8'h00, 6'b101000, "R9 start keeps sel");
        ev(0,0,1,1,0,8'h50, 6'b001000, "R6 mismatch clears");
        ev(1,0,0,0,0,8'h00, 6'b001000, "R9 start");
        ev(0,0,1,1,0,8'h00, 6'b010111, "R4 general call", 1'b1, 6'b100101);
        ev(1,0,0,0,0,8'h00, 6'b010010, "R9 start after gc");
        ev(0,0,1,1,0,8'h4A, 6'b100111, "R6 gc persists");
        ev(1,0,1,1,0,8'h50, 6'b100010, "R9 start beats byte");
        ev(0,1,1,1,0,8'h4A, 6'b000000, "R9 stop beats byte");
        ev(0,0,0,0,0,8'h00, 6'b000000, "R11 idle");
        // 10-bit mode, own 0x2A5
        @(negedge clk); cfg_ten_bit = 1'b1;
        ev(1,0,0,0,0,8'h00, 6'b000000, "R5 start");
        ev(0,0,1,1,0,8'hF4, 6'b000100, "R5 header write");
        ev(0,0,1,0,1,8'hA5, 6'b100101, "R5 low byte match");
        ev(1,0,0,0,0,8'h00, 6'b100000, "R9 repeated start");
        ev(0,0,1,1,0,8'hF5, 6'b101101, "R7 read after match");
        ev(0,0,1,0,0,8'h12, 6'b101000, "R10 data byte 10-bit");
        ev(0,1,0,0,0,8'h00, 6'b000000, "R6 stop");
        ev(1,0,0,0,0,8'h00, 6'b000000, "R7 start");
        ev(0,0,1,1,0,8'hF5, 6'b000000, "R7 read without match");
        ev(1,0,0,0,0,8'h00, 6'b000000, "R5 start");
        ev(0,0,1,1,0,8'hF4, 6'b000100, "R5 header write");
        ev(0,0,1,0,1,8'hA4, 6'b000000, "R5 low byte mismatch");
        ev(1,0,0,0,0,8'h00, 6'b000000, "R5 start");
        ev(0,0,1,1,0,8'hF6, 6'b000000, "R5 wrong upper bits");
        ev(1,0,0,0,0,8'h00, 6'b000000, "R8 start");
        ev(0,0,1,1,0,8'h4A, 6'b000000, "R8 7-bit byte in 10-bit mode");
        ev(1,0,0,0,0,8'h00, 6'b000000, "R4 start");
        ev(0,0,1,1,0,8'h00, 6'b010111, "R4 general call 10-bit");
        ev(0,1,0,0,0,8'h00, 6'b000000, "R6 stop");
        ev(0,0,0,0,0,8'h00, 6'b000000, "R8 idle");
        @(negedge clk); cfg_ten_bit = 1'b0;
        ev(1,0,0,0,0,8'h00, 6'b000000, "R8 start");
        ev(0,0,1,1,0,8'hF4, 6'b000000, "R8 header in 7-bit mode");
        ev(0,0,0,0,0,8'h00, 6'b000000, "R10 idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule